// File: doc/BRIEF.md
# UART Register Front End (16550 Programming Model)

This block is the software-facing half of a UART. It presents eight 8-bit registers on a 32-bit word bus, with one register per word. It holds the baud divisor, line format, interrupt enables, FIFO control, modem control and a scratch byte. Transmit and receive bytes are buffered in two parameterised FIFOs. It produces a line status byte, an interrupt identification byte and one level interrupt.

A separate serial engine sits behind the block. The engine reads the 16-bit divisor and the line control byte from it. It takes transmit bytes over a valid/ready pair and delivers received bytes over a second valid/ready pair. A driver uses the classic sequence: open the divisor latch, write both divisor bytes, close the latch with the wanted format, then enable the FIFOs. After that it polls line status or waits for the interrupt.

Top module: `uart_regfront`

## Requirements
- R1: After reset the divisor output is 1, the line control and interrupt enable registers read 0, line status reads 0x60, interrupt identification reads 0x01, the interrupt output is low and no transmit byte is offered.
- R2: The register index is byte address bits [4:2]. Indices 0 to 7 are, in order: data, interrupt enable, interrupt ID (read) / FIFO control (write), line control, modem control, line status, modem status, scratch. Scratch, modem control and line control read back what was written. Interrupt enable reads back only its low four bits.
- R3: While line control bit 7 is 1, index 0 reads and writes divisor bits [7:0] and index 1 reads and writes divisor bits [15:8]. These accesses do not touch the FIFOs or the interrupt enables, and the divisor output follows at once.
- R4: While line control bit 7 is 0, a write to index 0 appends a byte to the transmit FIFO. A read of index 0 returns and removes the oldest received byte. A read with the receive FIFO empty returns 0 and removes nothing.
- R5: The transmit valid output is high whenever the transmit FIFO holds a byte, and it presents the oldest byte. One byte leaves on each cycle in which valid and ready are both high.
- R6: FIFO control bit 0 enables the FIFOs. With it at 0, each direction holds one byte and a further transmit write is dropped. Any change of bit 0 empties both FIFOs.
- R7: FIFO control bit 1 empties the receive FIFO and bit 2 empties the transmit FIFO. Each empties its FIFO at the clock edge after the one that takes the write, and acts only once per write.
- R8: Line status bit 0 is 1 while a received byte waits. Bits 5 and 6 are 1 while the transmit FIFO is empty. Writes to line status and modem status have no effect, and modem status reads 0.
- R9: A byte offered on the receive side while the receive FIFO is full is discarded and sets line status bit 1. A read of line status returns the bit and then clears it. The receive ready output is always high.
- R10: The interrupt output is the OR of three terms: enable bit 0 with receive data waiting, enable bit 1 with the transmit FIFO empty, and enable bit 2 with the overrun flag. Enable bit 3 has no source.
- R11: Interrupt identification bit 0 is 0 when the interrupt is active. Bits [3:1] name the highest active source: overrun 011, above receive data 010, above transmit empty 001. Bits [7:6] are both 1 while the FIFOs are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address, register index in bits [4:2] |
| bus_wdata_i | input | BUS_W | Write data, low byte used |
| bus_rdata_o | output | BUS_W | Read data, valid in the access cycle, zero-extended |
| divisor_o | output | 16 | Baud divisor for the serial engine |
| line_ctrl_o | output | 8 | Line control byte for the serial engine |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_ready_i | input | 1 | Engine takes the transmit byte |
| tx_data_o | output | 8 | Oldest transmit byte |
| rx_valid_i | input | 1 | Engine offers a received byte |
| rx_ready_o | output | 1 | Always high, receive bytes are never stalled |
| rx_data_i | input | 8 | Received byte |
| irq_o | output | 1 | Combined level interrupt |

## Verification
Most internal faults show up at the ports within one or two cycles. A wrong FIFO pointer or count changes the order or number of bytes seen on the transmit data output, or on reads of index 0. It also flips line status bits 0, 5 and 6 on the next read. A faulty divisor-latch decode either moves the divisor output or leaks a byte into the transmit valid output on the very next cycle. Clear pulses are timed by watching the interrupt and valid outputs across the two edges that follow a control write. A lost or stuck overrun flag shows in the next line status read and on the interrupt output.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

   typedef enum logic [2:0] {
      RI_DATA = 3'd0,
      RI_IER  = 3'd1,
      RI_IIR  = 3'd2,
      RI_LCR  = 3'd3,
      RI_MCR  = 3'd4,
      RI_LSR  = 3'd5,
      RI_MSR  = 3'd6,
      RI_SCR  = 3'd7
   } reg_idx_e;

   localparam int REG_W     = 8;
   localparam int IDX_LO    = 2;
   localparam int IDX_HI    = 4;

   localparam int LCR_LATCH = 7;

   localparam int IE_RXD    = 0;
   localparam int IE_THRE   = 1;
   localparam int IE_LINE   = 2;
   localparam int IE_MODEM  = 3;

   localparam int FC_ENABLE = 0;
   localparam int FC_RXCLR  = 1;
   localparam int FC_TXCLR  = 2;

   localparam int LS_READY  = 0;
   localparam int LS_OVER   = 1;
   localparam int LS_THRE   = 5;
   localparam int LS_TEMT   = 6;

   localparam logic [2:0] ID_LINE = 3'b011;
   localparam logic [2:0] ID_RXD  = 3'b010;
   localparam logic [2:0] ID_THRE = 3'b001;
   localparam logic [2:0] ID_NONE = 3'b000;

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            clr_i,
   input  logic                            limit_one_i,
   input  logic                            push_i,
   input  logic [DATA_W-1:0]               wdata_i,
   input  logic                            pop_i,
   output logic [DATA_W-1:0]               rdata_o,
   output logic                            empty_o,
   output logic                            full_o,
   output logic [$clog2(DEPTH+1)-1:0]      count_o
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

   generate
      if (DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $fatal(1, "uart_rf_fifo: DEPTH must be a power of two");
      end
      if (DATA_W < 1) begin : g_bad_width
         $fatal(1, "uart_rf_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] count_q;
   logic             do_push;
   logic             do_pop;

   assign empty_o = (count_q == '0);
   assign full_o  = limit_one_i ? (count_q != '0) : (count_q == CAP);
   assign do_push = push_i & ~full_o;
   assign do_pop  = pop_i & ~empty_o;
   assign count_o = count_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q <= '0;
      end else if (clr_i) begin
         count_q <= '0;
      end else begin
         case ({do_push, do_pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [DATA_W-1:0] hold_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)      hold_q <= '0;
            else if (do_push) hold_q <= wdata_i;
         end
         assign rdata_o = hold_q;
      end else begin : g_ring
         logic [DATA_W-1:0] mem_q [DEPTH];
         logic [PTR_W-1:0]  wr_ptr_q;
         logic [PTR_W-1:0]  rd_ptr_q;

         always_ff @(posedge clk_i) begin
            if (do_push && !clr_i) mem_q[wr_ptr_q] <= wdata_i;
         end

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               wr_ptr_q <= '0;
               rd_ptr_q <= '0;
            end else if (clr_i) begin
               wr_ptr_q <= '0;
               rd_ptr_q <= '0;
            end else begin
               if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
               if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            end
         end

         assign rdata_o = mem_q[rd_ptr_q];

         AST_FIFO_EMPTY_POP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pop_i && empty_o && !clr_i) |=> $stable(rd_ptr_q)); // R4
      end
   endgenerate

   AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_q <= CAP); // R6

   AST_FIFO_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (count_q == '0)); // R7

endmodule

// File: rtl/uart_rf_ctrl.sv
module uart_rf_ctrl
   import uart_rf_pkg::*;
#(
   parameter logic [15:0] DIV_RESET = 16'd1,
   parameter logic [7:0]  LCR_RESET = 8'h00
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        wr_i,
   input  logic [2:0]  idx_i,
   input  logic [7:0]  wdata_i,
   output logic [7:0]  lcr_o,
   output logic [3:0]  ier_o,
   output logic [7:0]  mcr_o,
   output logic [7:0]  scr_o,
   output logic [15:0] div_o,
   output logic        fifo_en_o,
   output logic        rx_clr_o,
   output logic        tx_clr_o
);

   generate
      if (DIV_RESET == 16'd0) begin : g_bad_div
         $fatal(1, "uart_rf_ctrl: DIV_RESET must be nonzero");
      end
   endgenerate

   reg_idx_e    idx;
   logic        latch_open;
   logic [7:0]  lcr_q, mcr_q, scr_q;
   logic [3:0]  ier_q;
   logic [15:0] div_q;
   logic        fifo_en_q, rx_clr_q, tx_clr_q;
   logic        en_flip;

   assign idx        = reg_idx_e'(idx_i);
   assign latch_open = lcr_q[LCR_LATCH];
   assign en_flip    = wdata_i[FC_ENABLE] ^ fifo_en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lcr_q     <= LCR_RESET;
         mcr_q     <= '0;
         scr_q     <= '0;
         ier_q     <= '0;
         div_q     <= DIV_RESET;
         fifo_en_q <= 1'b0;
         rx_clr_q  <= 1'b0;
         tx_clr_q  <= 1'b0;
      end else begin
         rx_clr_q <= 1'b0;
         tx_clr_q <= 1'b0;
         if (wr_i) begin
            case (idx)
               RI_DATA: if (latch_open) div_q[7:0] <= wdata_i;
               RI_IER: begin
                  if (latch_open) div_q[15:8] <= wdata_i;
                  else            ier_q       <= wdata_i[3:0];
               end
               RI_IIR: begin
                  fifo_en_q <= wdata_i[FC_ENABLE];
                  rx_clr_q  <= wdata_i[FC_RXCLR] | en_flip;
                  tx_clr_q  <= wdata_i[FC_TXCLR] | en_flip;
               end
               RI_LCR:  lcr_q <= wdata_i;
               RI_MCR:  mcr_q <= wdata_i;
               RI_SCR:  scr_q <= wdata_i;
               default: ;
            endcase
         end
      end
   end

   assign lcr_o     = lcr_q;
   assign ier_o     = ier_q;
   assign mcr_o     = mcr_q;
   assign scr_o     = scr_q;
   assign div_o     = div_q;
   assign fifo_en_o = fifo_en_q;
   assign rx_clr_o  = rx_clr_q;
   assign tx_clr_o  = tx_clr_q;

   AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(div_o)); // R3

endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
   import uart_rf_pkg::*;
(
   input  logic [3:0] ier_i,
   input  logic       rx_avail_i,
   input  logic       tx_empty_i,
   input  logic       overrun_i,
   input  logic       fifo_en_i,
   output logic       irq_o,
   output logic [7:0] iid_o
);

   logic       src_line, src_rxd, src_thre;
   logic [2:0] id;
   logic       unused_modem;

   assign src_line = ier_i[IE_LINE] & overrun_i;
   assign src_rxd  = ier_i[IE_RXD]  & rx_avail_i;
   assign src_thre = ier_i[IE_THRE] & tx_empty_i;
   assign unused_modem = ier_i[IE_MODEM];

   always_comb begin
      if (src_line)      id = ID_LINE;
      else if (src_rxd)  id = ID_RXD;
      else if (src_thre) id = ID_THRE;
      else               id = ID_NONE;
   end

   assign irq_o = src_line | src_rxd | src_thre;
   assign iid_o = {fifo_en_i, fifo_en_i, 2'b00, id, ~irq_o};

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import uart_rf_pkg::*;
#(
   parameter int          ADDR_W    = 5,
   parameter int          BUS_W     = 32,
   parameter int          TX_DEPTH  = 16,
   parameter int          RX_DEPTH  = 16,
   parameter logic [15:0] DIV_RESET = 16'd1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sel_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [BUS_W-1:0]  bus_wdata_i,
   output logic [BUS_W-1:0]  bus_rdata_o,
   output logic [15:0]       divisor_o,
   output logic [7:0]        line_ctrl_o,
   output logic              tx_valid_o,
   input  logic              tx_ready_i,
   output logic [7:0]        tx_data_o,
   input  logic              rx_valid_i,
   output logic              rx_ready_o,
   input  logic [7:0]        rx_data_i,
   output logic              irq_o
);

   localparam int TX_CNT_W = $clog2(TX_DEPTH + 1);
   localparam int RX_CNT_W = $clog2(RX_DEPTH + 1);
   localparam int PAD_W    = BUS_W - REG_W;

   generate
      if (ADDR_W <= IDX_HI) begin : g_bad_addr
         $fatal(1, "uart_regfront: ADDR_W too small for eight word registers");
      end
      if (BUS_W < REG_W) begin : g_bad_bus
         $fatal(1, "uart_regfront: BUS_W narrower than a register");
      end
   endgenerate

   reg_idx_e      idx;
   logic          rd_acc, wr_acc;
   logic [7:0]    wbyte;
   logic [7:0]    lcr, mcr, scr;
   logic [3:0]    ier;
   logic          fifo_en, rx_clr, tx_clr, latch_open;
   logic          tx_push, tx_pop, tx_empty, tx_full;
   logic          rx_pop, rx_empty, rx_full;
   logic [7:0]    rx_head, iid, lsr, rd_byte;
   logic [TX_CNT_W-1:0] tx_count;
   logic [RX_CNT_W-1:0] rx_count;
   logic          overrun_q, lsr_read;
   logic          unused_bits;

   assign idx         = reg_idx_e'(bus_addr_i[IDX_HI:IDX_LO]);
   assign rd_acc      = bus_sel_i & ~bus_we_i;
   assign wr_acc      = bus_sel_i & bus_we_i;
   assign wbyte       = bus_wdata_i[REG_W-1:0];
   assign unused_bits = ^{bus_addr_i, bus_wdata_i, tx_full, rx_count, mcr[7:0] & 8'h00};

   uart_rf_ctrl #(
      .DIV_RESET (DIV_RESET),
      .LCR_RESET (8'h00)
   ) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_acc),
      .idx_i     (bus_addr_i[IDX_HI:IDX_LO]),
      .wdata_i   (wbyte),
      .lcr_o     (lcr),
      .ier_o     (ier),
      .mcr_o     (mcr),
      .scr_o     (scr),
      .div_o     (divisor_o),
      .fifo_en_o (fifo_en),
      .rx_clr_o  (rx_clr),
      .tx_clr_o  (tx_clr)
   );

   assign latch_open  = lcr[LCR_LATCH];
   assign line_ctrl_o = lcr;

   assign tx_push    = wr_acc & (idx == RI_DATA) & ~latch_open;
   assign tx_pop     = tx_valid_o & tx_ready_i;
   assign tx_valid_o = ~tx_empty;

   uart_rf_fifo #(
      .DATA_W (REG_W),
      .DEPTH  (TX_DEPTH)
   ) u_tx_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (tx_clr),
      .limit_one_i (~fifo_en),
      .push_i      (tx_push),
      .wdata_i     (wbyte),
      .pop_i       (tx_pop),
      .rdata_o     (tx_data_o),
      .empty_o     (tx_empty),
      .full_o      (tx_full),
      .count_o     (tx_count)
   );

   assign rx_pop     = rd_acc & (idx == RI_DATA) & ~latch_open;
   assign rx_ready_o = 1'b1;

   uart_rf_fifo #(
      .DATA_W (REG_W),
      .DEPTH  (RX_DEPTH)
   ) u_rx_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (rx_clr),
      .limit_one_i (~fifo_en),
      .push_i      (rx_valid_i),
      .wdata_i     (rx_data_i),
      .pop_i       (rx_pop),
      .rdata_o     (rx_head),
      .empty_o     (rx_empty),
      .full_o      (rx_full),
      .count_o     (rx_count)
   );

   assign lsr_read = rd_acc & (idx == RI_LSR);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    overrun_q <= 1'b0;
      else if (rx_valid_i && rx_full) overrun_q <= 1'b1;
      else if (lsr_read)              overrun_q <= 1'b0;
   end

   always_comb begin
      lsr            = '0;
      lsr[LS_READY]  = ~rx_empty;
      lsr[LS_OVER]   = overrun_q;
      lsr[LS_THRE]   = tx_empty;
      lsr[LS_TEMT]   = tx_empty;
   end

   uart_rf_irq u_irq (
      .ier_i      (ier),
      .rx_avail_i (~rx_empty),
      .tx_empty_i (tx_empty),
      .overrun_i  (overrun_q),
      .fifo_en_i  (fifo_en),
      .irq_o      (irq_o),
      .iid_o      (iid)
   );

   always_comb begin
      case (idx)
         RI_DATA: rd_byte = latch_open ? divisor_o[7:0]
                                       : (rx_empty ? 8'h00 : rx_head);
         RI_IER:  rd_byte = latch_open ? divisor_o[15:8] : {4'b0000, ier};
         RI_IIR:  rd_byte = iid;
         RI_LCR:  rd_byte = lcr;
         RI_MCR:  rd_byte = mcr;
         RI_LSR:  rd_byte = lsr;
         RI_MSR:  rd_byte = 8'h00;
         default: rd_byte = scr;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign bus_rdata_o = rd_acc ? {{PAD_W{1'b0}}, rd_byte} : '0;
      end else begin : g_nopad
         assign bus_rdata_o = rd_acc ? rd_byte : '0;
      end
   endgenerate

   AST_LATCH_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_acc && idx == RI_DATA && latch_open && !tx_clr && !tx_pop)
      |=> $stable(tx_count)); // R3

   AST_TX_HEAD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_valid_o && !tx_ready_i && !tx_clr) |=> (tx_valid_o && $stable(tx_data_o))); // R5

   AST_OVERRUN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_valid_i && rx_full) |=> overrun_q); // R9

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ier == 4'h0) |-> !irq_o); // R10

endmodule

// File: tb/uart_regfront_bench.sv
`timescale 1ns/1ps
module uart_regfront_bench;

   localparam int RXD = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, we = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] divisor;
   logic [7:0]  lctl;
   logic        tx_valid, tx_ready = 1'b0;
   logic [7:0]  tx_data;
   logic        rx_valid = 1'b0, rx_ready;
   logic [7:0]  rx_data = '0;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_regfront u_uart_regfront (
      .clk_i(clk), .rst_ni(rst_n),
      .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .divisor_o(divisor), .line_ctrl_o(lctl),
      .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
      .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
      .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] idx, input logic [7:0] v);
      @(negedge clk);
      sel = 1'b1; we = 1'b1; addr = {idx, 2'b00}; wdata = {24'hABCDEF, v};
      @(negedge clk);
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [7:0] v);
      @(negedge clk);
      sel = 1'b1; we = 1'b0; addr = {idx, 2'b00};
      #2;
      v = rdata[7:0];
      if (rdata[31:8] !== 24'h0) v = 8'hXX;
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic rx_send(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic tx_take();
      @(negedge clk);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 divisor", divisor, 16'd1);
      chk("R1 line ctrl out", lctl, 8'h00);
      chk("R1 irq", irq, 1'b0);
      chk("R1 tx valid", tx_valid, 1'b0);
      chk("R9 rx ready", rx_ready, 1'b1);
      rd(3'd5, v); chk("R1 line status", v, 8'h60);
      rd(3'd1, v); chk("R1 int enable", v, 8'h00);
      rd(3'd2, v); chk("R11 reset ident", v, 8'h01);
      rd(3'd6, v); chk("R8 modem status", v, 8'h00);
   endtask

   task automatic t_regmap();
      logic [7:0] v;
      wr(3'd7, 8'hA5); rd(3'd7, v); chk("R2 scratch", v, 8'hA5);
      wr(3'd4, 8'h5A); rd(3'd4, v); chk("R2 modem ctrl", v, 8'h5A);
      wr(3'd1, 8'hFF); rd(3'd1, v); chk("R2 int enable mask", v, 8'h0F);
      wr(3'd1, 8'h00);
      wr(3'd3, 8'h1B); rd(3'd3, v); chk("R2 line ctrl", v, 8'h1B);
      chk("R2 line ctrl out", lctl, 8'h1B);
   endtask

   task automatic t_latch();
      logic [7:0] v;
      wr(3'd3, 8'h83);
      wr(3'd0, 8'h34);
      wr(3'd1, 8'h12);
      chk("R3 divisor out", divisor, 16'h1234);
      chk("R3 no tx push", tx_valid, 1'b0);
      rd(3'd0, v); chk("R3 divisor low", v, 8'h34);
      rd(3'd1, v); chk("R3 divisor high", v, 8'h12);
      wr(3'd3, 8'h03);
      chk("R3 format out", lctl, 8'h03);
      rd(3'd1, v); chk("R3 enables untouched", v, 8'h00);
      rd(3'd0, v); chk("R4 empty read zero", v, 8'h00);
      chk("R3 divisor kept", divisor, 16'h1234);
   endtask

   task automatic t_readonly();
      logic [7:0] v;
      wr(3'd5, 8'h00);
      wr(3'd6, 8'hFF);
      rd(3'd5, v); chk("R8 status write ignored", v, 8'h60);
      rd(3'd6, v); chk("R8 modem status write ignored", v, 8'h00);
   endtask

   task automatic t_tx();
      logic [7:0] v;
      wr(3'd2, 8'h01);
      wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
      chk("R5 valid", tx_valid, 1'b1);
      chk("R5 oldest first", tx_data, 8'h11);
      rd(3'd5, v); chk("R8 tx not empty", v, 8'h00);
      tx_take();
      chk("R5 one pop", tx_data, 8'h22);
      wr(3'd2, 8'h05);
      chk("R7 not yet cleared", tx_valid, 1'b1);
      @(negedge clk);
      chk("R7 tx cleared", tx_valid, 1'b0);
      rd(3'd5, v); chk("R8 tx empty again", v, 8'h60);
   endtask

   task automatic t_rx();
      logic [7:0] v;
      rx_send(8'hA1); rx_send(8'hB2);
      rd(3'd5, v); chk("R8 data ready", v, 8'h61);
      rd(3'd0, v); chk("R4 first byte", v, 8'hA1);
      rd(3'd0, v); chk("R4 second byte", v, 8'hB2);
      rd(3'd0, v); chk("R4 empty read", v, 8'h00);
      rd(3'd5, v); chk("R4 empty stays empty", v, 8'h60);
      rx_send(8'hC3); rx_send(8'hD4);
      wr(3'd1, 8'h01);
      chk("R10 rx irq", irq, 1'b1);
      wr(3'd2, 8'h03);
      chk("R7 rx clear pending", irq, 1'b1);
      @(negedge clk);
      chk("R7 rx cleared", irq, 1'b0);
      wr(3'd1, 8'h00);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(3'd1, 8'h02);
      chk("R10 tx empty irq", irq, 1'b1);
      rd(3'd2, v); chk("R11 thre id", v, 8'hC2);
      wr(3'd1, 8'h01);
      chk("R10 rx only quiet", irq, 1'b0);
      rd(3'd2, v); chk("R11 none id", v, 8'hC1);
      rx_send(8'h5A);
      chk("R10 rx irq", irq, 1'b1);
      wr(3'd1, 8'h0B);
      rd(3'd2, v); chk("R11 rx over thre", v, 8'hC4);
      rd(3'd0, v); chk("R4 drain", v, 8'h5A);
      rd(3'd2, v); chk("R11 thre after drain", v, 8'hC2);
      wr(3'd1, 8'h08);
      chk("R10 modem no source", irq, 1'b0);
      wr(3'd1, 8'h04);
      for (int i = 0; i <= RXD; i++) rx_send(8'(i));
      chk("R9 overrun irq", irq, 1'b1);
      wr(3'd1, 8'h07);
      rd(3'd2, v); chk("R11 line top", v, 8'hC6);
      wr(3'd1, 8'h04);
      rd(3'd5, v); chk("R9 overrun flag", v, 8'h63);
      chk("R9 cleared by read", irq, 1'b0);
      rd(3'd5, v); chk("R9 flag gone", v, 8'h61);
      rd(3'd0, v); chk("R9 oldest kept", v, 8'h00);
      wr(3'd2, 8'h03);
      wr(3'd1, 8'h00);
   endtask

   task automatic t_single();
      logic [7:0] v;
      wr(3'd2, 8'h00);
      wr(3'd0, 8'h55); wr(3'd0, 8'h66);
      chk("R6 first held", tx_data, 8'h55);
      tx_take();
      chk("R6 second dropped", tx_valid, 1'b0);
      rx_send(8'h77); rx_send(8'h88);
      rd(3'd5, v); chk("R9 single overrun", v, 8'h63);
      rd(3'd0, v); chk("R6 single rx", v, 8'h77);
      rd(3'd5, v); chk("R6 rx empty", v, 8'h60);
      rd(3'd2, v); chk("R11 disabled none", v, 8'h01);
      rx_send(8'h99);
      wr(3'd2, 8'h01);
      rd(3'd5, v); chk("R6 enable flip clears", v, 8'h60);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_latch();
      t_readonly();
      t_tx();
      t_rx();
      t_irq();
      t_single();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule